// File: doc/BRIEF.md
# Modem Command Decoder and Status Unit

This block is the device-side logic behind the command port of a low-rate uplink radio modem. An SPI slave shifter in front of it delivers each received byte with a one-cycle strobe, and it presents the byte to shift out next. A frame opens when chip select becomes active. Its first byte is an opcode, and the block then either collects arguments or serves read data. Read data starts at frame byte 2, because byte 1 is a dummy.

The block keeps the transmit payload buffer, the direction and output registers of a 6-bit general-purpose port, and the carrier frequency word. It also keeps the status flags and drives an active-low event line that tells the external host to read status. Completion of power-up, of a transmission, of a measurement or of a configuration write is reported by one-cycle pulses from stubs outside this block. Send-frame and start-measurement commands leave the block as one-cycle request pulses.

The control FSM has four states:
- `ST_IDLE`: no frame is open.
- `ST_OPC`: waiting for the opcode.
- `ST_DATA`: a supported opcode is being served.
- `ST_SINK`: an unsupported opcode was received, and the rest of the frame is discarded.

Its transitions are:
- IDLE→OPC when chip select becomes active.
- OPC→DATA on a supported opcode byte.
- OPC→SINK on an unsupported opcode byte.
- Any state→IDLE when chip select drops.

Top module: `modem_cmd_ctrl`

## Requirements
- R1: After reset the outputs are as follows. `event_n`=1, `port_dir`=0x00 and `port_out`=0x3F. `freq_word`=868130000, `pl_len`=0, `payload`=0 and `tx_byte`=0x00.
- R2: A pulse on `ready_p`, `frame_done_p`, `meas_done_p` or `cfg_done_p` drives `event_n` low from the next cycle on.
- R3: A status frame uses opcode 0x0A. It returns 0x00 at byte 2, the device status byte at byte 3 and 0x00 at byte 4. When chip select drops at the end of that frame, `event_n` returns high and the ready bit, the frame-sent bit and the error code are cleared. A completion pulse in that same cycle wins over the clear.
- R4: The device status byte is laid out as follows. Bit 7 is 0, bit 6 is ready, bit 5 is frame sent, bits 4:1 are the error code and bit 0 is the live `pa_on` input.
- R5: An opcode outside the set {0x02,0x03,0x04,0x07,0x0A,0x0D,0x0F,0x12,0x14,0x1B} sets error code 0001 and drives `event_n` low. The remaining bytes of that frame change no register.
- R6: Opcode 0x07 first clears the whole buffer and `pl_len`. Frame bytes 1..12 then go to slots 0..11, where slot i is `payload[8i+7:8i]`, and `pl_len` equals the number of bytes stored. Bytes after the 12th are ignored.
- R7: Opcode 0x02 loads byte 1 into `port_dir` with bit 0 forced to 0. Opcode 0x03 loads byte 1 into `port_out` with bit 0 forced to 1.
- R8: Opcode 0x04 returns the value of `pins_in` at byte 2, with bit 0 forced to 1 and bits 7:6 zero.
- R9: Opcode 0x0F returns the 16 access-code bytes at frame bytes 2..17. Code byte j comes from bits [8j+7:8j] of the 64-bit code parameter for j<8. Bytes 8..15 are 0x00.
- R10: Opcode 0x12 returns the 32-bit identity at frame bytes 2..5, bits 31:24 first.
- R11: Opcode 0x1B takes frame bytes 1..4 as a frequency, most significant byte first. After the 4th byte the value is applied if it lies in 868000000..868600000 inclusive. Otherwise `freq_word` is kept and error code 0011 is set.
- R12: Opcode 0x0D gives a one-cycle `send_req` pulse, and opcode 0x14 gives a one-cycle `meas_req` pulse. Each pulse appears in the cycle after the opcode strobe.
- R13: `tx_byte` changes only in the cycle after a byte strobe, to the byte for the next frame position. It is 0x00 for every position no requirement defines, and 0x00 whenever chip select is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_active | input | 1 | High while a command frame is open |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on `rx_byte` |
| rx_byte | input | 8 | Byte received from the shifter |
| tx_byte | output | 8 | Byte for the shifter to send at the next frame position |
| ready_p | input | 1 | Power-up or reset completion pulse |
| frame_done_p | input | 1 | Transmission completion pulse |
| meas_done_p | input | 1 | Measurement completion pulse |
| cfg_done_p | input | 1 | Configuration write completion pulse |
| pa_on | input | 1 | Power amplifier is active |
| pins_in | input | 6 | Port pin levels |
| event_n | output | 1 | Active-low event line |
| port_dir | output | 6 | Port direction register (1 = output) |
| port_out | output | 6 | Port output/pull-up register |
| freq_word | output | 32 | Carrier frequency in Hz |
| payload | output | 96 | Payload slots, slot 0 in the low byte |
| pl_len | output | 4 | Number of valid payload bytes |
| send_req | output | 1 | Request to send a frame |
| meas_req | output | 1 | Request to start a measurement |

## Verification
A wrong FSM state shows up in `tx_byte` one cycle after the next byte strobe, either as read data at a position that should carry 0x00 or the reverse. A bad argument index shows up in the payload, port or frequency outputs in the cycle after the offending byte. Errors in the status flags show on `event_n` in the cycle after a pulse or after a status frame closes. Stale error codes or ready and frame-sent bits show in byte 3 of the next status frame. Because the bench model is compared on every clock, each of these errors is reported in the cycle where it first appears.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    typedef enum logic [1:0] {ST_IDLE, ST_OPC, ST_DATA, ST_SINK} cmd_st_t;

    localparam logic [7:0] OP_DIR_WR  = 8'h02;
    localparam logic [7:0] OP_OUT_WR  = 8'h03;
    localparam logic [7:0] OP_PIN_RD  = 8'h04;
    localparam logic [7:0] OP_BUF_WR  = 8'h07;
    localparam logic [7:0] OP_STAT_RD = 8'h0A;
    localparam logic [7:0] OP_SEND    = 8'h0D;
    localparam logic [7:0] OP_PAC_RD  = 8'h0F;
    localparam logic [7:0] OP_ID_RD   = 8'h12;
    localparam logic [7:0] OP_MEAS    = 8'h14;
    localparam logic [7:0] OP_FREQ_WR = 8'h1B;

    localparam logic [3:0] ERR_NONE    = 4'h0;
    localparam logic [3:0] ERR_BAD_CMD = 4'h1;
    localparam logic [3:0] ERR_FREQ    = 4'h3;

    function automatic logic op_known(input logic [7:0] op);
        case (op)
            OP_DIR_WR, OP_OUT_WR, OP_PIN_RD, OP_BUF_WR, OP_STAT_RD,
            OP_SEND, OP_PAC_RD, OP_ID_RD, OP_MEAS, OP_FREQ_WR: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mdm_evt_status.sv
module mdm_evt_status
    import mdm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] done_p,     // [0] ready, [1] frame sent, [2] measure, [3] config
    input  logic       bad_cmd,
    input  logic       freq_bad,
    input  logic       clr,
    input  logic       pa_on,
    output logic       event_n,
    output logic [7:0] dev_status
);

    logic       ev_q;
    logic       rdy_q;
    logic       sent_q;
    logic [3:0] err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q   <= 1'b0;
            rdy_q  <= 1'b0;
            sent_q <= 1'b0;
            err_q  <= ERR_NONE;
        end else begin
            if ((|done_p) || bad_cmd) ev_q <= 1'b1;
            else if (clr)             ev_q <= 1'b0;

            if (done_p[0]) rdy_q <= 1'b1;
            else if (clr)  rdy_q <= 1'b0;

            if (done_p[1]) sent_q <= 1'b1;
            else if (clr)  sent_q <= 1'b0;

            if (bad_cmd)       err_q <= ERR_BAD_CMD;
            else if (freq_bad) err_q <= ERR_FREQ;
            else if (clr)      err_q <= ERR_NONE;
        end
    end

    assign event_n    = ~ev_q;
    assign dev_status = {1'b0, rdy_q, sent_q, err_q, pa_on};

    // R2
    ev_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|done_p) || bad_cmd) |=> !event_n);

    // R3
    ev_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(|done_p) && !bad_cmd && !freq_bad) |=> (event_n && dev_status[6:1] == 6'd0));

    // R4
    rdy_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_p[0] |=> dev_status[6]);

endmodule

// File: rtl/mdm_payload_buf.sv
module mdm_payload_buf #(
    parameter int PL_MAX = 12,
    localparam int LEN_W = $clog2(PL_MAX + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  wr_en,
    input  logic [LEN_W-1:0]      wr_slot,
    input  logic [7:0]            wr_data,
    output logic [PL_MAX*8-1:0]   payload,
    output logic [LEN_W-1:0]      pl_len
);

    for (genvar s = 0; s < PL_MAX; s++) begin : g_slot
        logic [7:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              slot_q <= 8'h00;
            else if (clr)                            slot_q <= 8'h00;
            else if (wr_en && wr_slot == LEN_W'(s))  slot_q <= wr_data;
        end
        assign payload[8*s +: 8] = slot_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pl_len <= '0;
        else if (clr)   pl_len <= '0;
        else if (wr_en) pl_len <= wr_slot + LEN_W'(1);
    end

    // R6
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pl_len <= LEN_W'(PL_MAX));

endmodule

// File: rtl/mdm_resp_sel.sv
module mdm_resp_sel
    import mdm_pkg::*;
#(
    parameter int          PORT_W     = 6,
    parameter int          IDX_W      = 5,
    parameter int          PAC_BYTES  = 16,
    parameter int          PAC_STORED = 8,
    parameter logic [PAC_STORED*8-1:0] PAC_LO = 64'h0123_4567_89AB_CDEF,
    parameter int          ID_BYTES   = 4,
    parameter logic [ID_BYTES*8-1:0]   DEV_ID = 32'hA1B2_C3D4
) (
    input  logic [7:0]        op,
    input  logic [IDX_W-1:0]  nidx,
    input  logic [7:0]        dev_status,
    input  logic [PORT_W-1:0] pins,
    output logic [7:0]        rbyte
);

    localparam logic [PAC_BYTES*8-1:0] PAC_FULL = (PAC_BYTES*8)'(PAC_LO);

    logic [7:0] pin_byte;
    assign pin_byte = 8'({pins[PORT_W-1:1], pins[0] | 1'b1});

    always_comb begin
        rbyte = 8'h00;
        case (op)
            OP_STAT_RD: if (nidx == IDX_W'(3)) rbyte = dev_status;
            OP_PIN_RD:  if (nidx == IDX_W'(2)) rbyte = pin_byte;
            OP_PAC_RD: begin
                for (int j = 0; j < PAC_BYTES; j++)
                    if (nidx == IDX_W'(j + 2)) rbyte = PAC_FULL[8*j +: 8];
            end
            OP_ID_RD: begin
                for (int j = 0; j < ID_BYTES; j++)
                    if (nidx == IDX_W'(j + 2)) rbyte = DEV_ID[8*(ID_BYTES-1-j) +: 8];
            end
            default: rbyte = 8'h00;
        endcase
    end

endmodule

// File: rtl/modem_cmd_ctrl.sv
module modem_cmd_ctrl
    import mdm_pkg::*;
#(
    parameter int          PL_MAX     = 12,
    parameter int          PORT_W     = 6,
    parameter int          PAC_BYTES  = 16,
    parameter int          PAC_STORED = 8,
    parameter logic [PAC_STORED*8-1:0] PAC_LO = 64'h0123_4567_89AB_CDEF,
    parameter int          ID_BYTES   = 4,
    parameter logic [ID_BYTES*8-1:0]   DEV_ID = 32'hA1B2_C3D4,
    parameter logic [31:0] F_MIN      = 32'd868000000,
    parameter logic [31:0] F_MAX      = 32'd868600000,
    parameter logic [31:0] F_DEF      = 32'd868130000,
    localparam int LEN_W = $clog2(PL_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_active,
    input  logic                 rx_valid,
    input  logic [7:0]           rx_byte,
    output logic [7:0]           tx_byte,
    input  logic                 ready_p,
    input  logic                 frame_done_p,
    input  logic                 meas_done_p,
    input  logic                 cfg_done_p,
    input  logic                 pa_on,
    input  logic [PORT_W-1:0]    pins_in,
    output logic                 event_n,
    output logic [PORT_W-1:0]    port_dir,
    output logic [PORT_W-1:0]    port_out,
    output logic [31:0]          freq_word,
    output logic [PL_MAX*8-1:0]  payload,
    output logic [LEN_W-1:0]     pl_len,
    output logic                 send_req,
    output logic                 meas_req
);

    localparam int IDX_W     = $clog2(PAC_BYTES + 3);
    localparam int FREQ_LAST = 4;

    cmd_st_t            st_q, st_d;
    logic [7:0]         op_q;
    logic [IDX_W-1:0]   idx_q, nidx;
    logic [23:0]        facc_q;
    logic [PORT_W-1:0]  dir_q, out_q;
    logic [31:0]        freq_q, freq_val;
    logic [7:0]         tx_q, resp_w, stat_w;
    logic               send_q, meas_q;
    logic               rx_take, opc_hit, data_hit, bad_cmd, clr_stat;
    logic               freq_last, freq_ok, freq_bad, buf_clr, buf_wr;

    assign rx_take   = rx_valid && cs_active;
    assign opc_hit   = (st_q == ST_OPC) && rx_take;
    assign data_hit  = (st_q == ST_DATA) && rx_take;
    assign bad_cmd   = opc_hit && !op_known(rx_byte);
    assign clr_stat  = (st_q == ST_DATA) && !cs_active && (op_q == OP_STAT_RD);
    assign freq_val  = {facc_q, rx_byte};
    assign freq_last = data_hit && (op_q == OP_FREQ_WR) && (idx_q == IDX_W'(FREQ_LAST));
    assign freq_ok   = (freq_val >= F_MIN) && (freq_val <= F_MAX);
    assign freq_bad  = freq_last && !freq_ok;
    assign buf_clr   = opc_hit && (rx_byte == OP_BUF_WR);
    assign buf_wr    = data_hit && (op_q == OP_BUF_WR) &&
                       (idx_q >= IDX_W'(1)) && (idx_q <= IDX_W'(PL_MAX));
    assign nidx      = (idx_q == '1) ? idx_q : idx_q + IDX_W'(1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (!cs_active) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: st_d = ST_OPC;
                ST_OPC:  if (rx_valid) st_d = op_known(rx_byte) ? ST_DATA : ST_SINK;
                ST_DATA: st_d = ST_DATA;
                ST_SINK: st_d = ST_SINK;
            endcase
        end
    end

    // outputs and command registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= 8'h00;
            idx_q  <= '0;
            facc_q <= 24'h0;
            dir_q  <= '0;
            out_q  <= '1;
            freq_q <= F_DEF;
            tx_q   <= 8'h00;
            send_q <= 1'b0;
            meas_q <= 1'b0;
        end else begin
            send_q <= opc_hit && (rx_byte == OP_SEND);
            meas_q <= opc_hit && (rx_byte == OP_MEAS);

            if (!cs_active || st_q == ST_IDLE) tx_q <= 8'h00;
            else if (rx_take) tx_q <= (st_q == ST_DATA) ? resp_w : 8'h00;

            if (opc_hit) begin
                op_q  <= rx_byte;
                idx_q <= IDX_W'(1);
            end

            if (data_hit) begin
                idx_q <= nidx;
                if (op_q == OP_DIR_WR && idx_q == IDX_W'(1))
                    dir_q <= {rx_byte[PORT_W-1:1], 1'b0};
                if (op_q == OP_OUT_WR && idx_q == IDX_W'(1))
                    out_q <= {rx_byte[PORT_W-1:1], 1'b1};
                if (op_q == OP_FREQ_WR && idx_q >= IDX_W'(1) && idx_q <= IDX_W'(FREQ_LAST))
                    facc_q <= {facc_q[15:0], rx_byte};
                if (freq_last && freq_ok)
                    freq_q <= freq_val;
            end
        end
    end

    mdm_evt_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_p     ({cfg_done_p, meas_done_p, frame_done_p, ready_p}),
        .bad_cmd    (bad_cmd),
        .freq_bad   (freq_bad),
        .clr        (clr_stat),
        .pa_on      (pa_on),
        .event_n    (event_n),
        .dev_status (stat_w)
    );

    mdm_payload_buf #(.PL_MAX(PL_MAX)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .wr_en   (buf_wr),
        .wr_slot (LEN_W'(idx_q - IDX_W'(1))),
        .wr_data (rx_byte),
        .payload (payload),
        .pl_len  (pl_len)
    );

    mdm_resp_sel #(
        .PORT_W(PORT_W), .IDX_W(IDX_W), .PAC_BYTES(PAC_BYTES), .PAC_STORED(PAC_STORED),
        .PAC_LO(PAC_LO), .ID_BYTES(ID_BYTES), .DEV_ID(DEV_ID)
    ) u_resp (
        .op         (op_q),
        .nidx       (nidx),
        .dev_status (stat_w),
        .pins       (pins_in),
        .rbyte      (resp_w)
    );

    assign tx_byte   = tx_q;
    assign port_dir  = dir_q;
    assign port_out  = out_q;
    assign freq_word = freq_q;
    assign send_req  = send_q;
    assign meas_req  = meas_q;

    // R5
    bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cmd |=> (!event_n && stat_w[4:1] == ERR_BAD_CMD));

    // R7
    dir_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_hit && op_q == OP_DIR_WR && idx_q == IDX_W'(1)) |=>
        (port_dir[PORT_W-1:1] == $past(rx_byte[PORT_W-1:1]) && !port_dir[0]));

    // R11
    freq_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_word >= F_MIN) && (freq_word <= F_MAX));

    // R13
    tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> (tx_byte == 8'h00));

    // R12
    send_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        send_req |=> !send_req);

endmodule

// File: tb/modem_cmd_ctrl_tb_top.sv
module modem_cmd_ctrl_tb_top;

    localparam logic [63:0] PAC_V = 64'h0123_4567_89AB_CDEF;
    localparam logic [31:0] ID_V  = 32'hA1B2_C3D4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0, cs = 1'b0, rxv = 1'b0, pa = 1'b0;
    logic [7:0]  rxb = 8'h00;
    logic [3:0]  done_p = 4'h0;
    logic [5:0]  pins = 6'h00;

    logic [7:0]  tx_byte;
    logic        event_n, send_req, meas_req;
    logic [5:0]  port_dir, port_out;
    logic [31:0] freq_word;
    logic [95:0] payload;
    logic [3:0]  pl_len;

    modem_cmd_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cs_active(cs), .rx_valid(rxv), .rx_byte(rxb),
        .tx_byte(tx_byte), .ready_p(done_p[0]), .frame_done_p(done_p[1]),
        .meas_done_p(done_p[2]), .cfg_done_p(done_p[3]), .pa_on(pa), .pins_in(pins),
        .event_n(event_n), .port_dir(port_dir), .port_out(port_out), .freq_word(freq_word),
        .payload(payload), .pl_len(pl_len), .send_req(send_req), .meas_req(meas_req)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int          m_st, m_idx, m_len;
    logic [7:0]  m_op, m_tx;
    logic        m_ev, m_rdy, m_sent, m_snd, m_mea;
    logic [3:0]  m_err;
    logic [5:0]  m_dir, m_out;
    logic [31:0] m_freq, m_acc;
    logic [7:0]  m_buf [12];

    function automatic bit known(input logic [7:0] op);
        return op inside {8'h02, 8'h03, 8'h04, 8'h07, 8'h0A, 8'h0D, 8'h0F, 8'h12, 8'h14, 8'h1B};
    endfunction

    function automatic logic [7:0] m_resp(input logic [7:0] op, input int n,
                                          input logic [7:0] st, input logic [5:0] pn);
        logic [63:0] sh;
        logic [31:0] si;
        if (op == 8'h0A && n == 3) return st;
        if (op == 8'h04 && n == 2) return {2'b00, pn[5:1], 1'b1};
        if (op == 8'h0F && n >= 2 && n <= 17) begin
            if (n - 2 >= 8) return 8'h00;
            sh = PAC_V >> (8 * (n - 2));
            return sh[7:0];
        end
        if (op == 8'h12 && n >= 2 && n <= 5) begin
            si = ID_V >> (8 * (5 - n));
            return si[7:0];
        end
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_idx = 0; m_len = 0; m_op = 0; m_tx = 0;
            m_ev = 0; m_rdy = 0; m_sent = 0; m_snd = 0; m_mea = 0; m_err = 0;
            m_dir = 0; m_out = 6'h3F; m_freq = 32'd868130000; m_acc = 0;
            for (int i = 0; i < 12; i++) m_buf[i] = 0;
        end else begin
            logic bad, fbad, clr, sp, mp;
            logic [7:0] ntx, stb;
            logic [31:0] fv;
            bad = 0; fbad = 0; clr = 0; sp = 0; mp = 0; ntx = m_tx;
            stb = {1'b0, m_rdy, m_sent, m_err, pa};
            if (!cs) begin
                if (m_st == 2 && m_op == 8'h0A) clr = 1;
                m_st = 0; ntx = 0;
            end else if (m_st == 0) begin
                m_st = 1; ntx = 0;
            end else if (rxv) begin
                if (m_st == 1) begin
                    m_op = rxb; m_idx = 1; ntx = 0;
                    if (known(rxb)) m_st = 2; else begin m_st = 3; bad = 1; end
                    if (rxb == 8'h07) begin
                        m_len = 0;
                        for (int i = 0; i < 12; i++) m_buf[i] = 0;
                    end
                    sp = (rxb == 8'h0D);
                    mp = (rxb == 8'h14);
                end else if (m_st == 2) begin
                    if (m_op == 8'h02 && m_idx == 1) m_dir = {rxb[5:1], 1'b0};
                    if (m_op == 8'h03 && m_idx == 1) m_out = {rxb[5:1], 1'b1};
                    if (m_op == 8'h07 && m_idx >= 1 && m_idx <= 12) begin
                        m_buf[m_idx-1] = rxb; m_len = m_idx;
                    end
                    if (m_op == 8'h1B && m_idx >= 1 && m_idx <= 4) begin
                        fv = {m_acc[23:0], rxb};
                        m_acc = fv;
                        if (m_idx == 4) begin
                            if (fv >= 32'd868000000 && fv <= 32'd868600000) m_freq = fv;
                            else fbad = 1;
                        end
                    end
                    ntx = m_resp(m_op, m_idx + 1, stb, pins);
                    if (m_idx < 31) m_idx = m_idx + 1;
                end else begin
                    ntx = 0;
                end
            end
            if ((|done_p) || bad) m_ev = 1; else if (clr) m_ev = 0;
            if (done_p[0]) m_rdy = 1; else if (clr) m_rdy = 0;
            if (done_p[1]) m_sent = 1; else if (clr) m_sent = 0;
            if (bad) m_err = 4'h1; else if (fbad) m_err = 4'h3; else if (clr) m_err = 4'h0;
            m_snd = sp; m_mea = mp; m_tx = ntx;
        end
    end

    int cnt_snd = 0, cnt_mea = 0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [95:0] ep;
            for (int i = 0; i < 12; i++) ep[8*i +: 8] = m_buf[i];
            chk("R2 event_n model", 128'(event_n), 128'(!m_ev));
            chk("R7 port_dir model", 128'(port_dir), 128'(m_dir));
            chk("R7 port_out model", 128'(port_out), 128'(m_out));
            chk("R11 freq_word model", 128'(freq_word), 128'(m_freq));
            chk("R6 pl_len model", 128'(pl_len), 128'(m_len));
            chk("R6 payload model", 128'(payload), 128'(ep));
            chk("R13 tx_byte model", 128'(tx_byte), 128'(m_tx));
            chk("R12 send_req model", 128'(send_req), 128'(m_snd));
            chk("R12 meas_req model", 128'(meas_req), 128'(m_mea));
            if (send_req) cnt_snd++;
            if (meas_req) cnt_mea++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(); @(negedge clk); endtask
    task automatic fbeg(); cs = 1'b1; tick(); tick(); endtask
    task automatic fend(); cs = 1'b0; tick(); tick(); endtask
    task automatic sbyte(input logic [7:0] b);
        rxb = b; rxv = 1'b1; tick(); rxv = 1'b0; tick();
    endtask
    task automatic pulse(input int k);
        done_p[k] = 1'b1; tick(); done_p = 4'h0; tick();
    endtask
    task automatic stat_rd(output logic [7:0] dev);
        fbeg(); sbyte(8'h0A); sbyte(8'h00);
        chk("R3 status byte2", 128'(tx_byte), 128'(8'h00));
        sbyte(8'h00); dev = tx_byte;
        sbyte(8'h00);
        chk("R3 status byte4", 128'(tx_byte), 128'(8'h00));
        sbyte(8'h00); fend();
    endtask
    task automatic wr_freq(input logic [31:0] v);
        fbeg(); sbyte(8'h1B); sbyte(v[31:24]); sbyte(v[23:16]); sbyte(v[15:8]); sbyte(v[7:0]); fend();
    endtask

    initial begin
        logic [7:0] d;
        int c0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1
        chk("R1 event_n", 128'(event_n), 128'(1'b1));
        chk("R1 port_dir", 128'(port_dir), 128'(6'h00));
        chk("R1 port_out", 128'(port_out), 128'(6'h3F));
        chk("R1 freq", 128'(freq_word), 128'(32'd868130000));
        chk("R1 pl_len", 128'(pl_len), 128'(4'd0));
        chk("R1 tx_byte", 128'(tx_byte), 128'(8'h00));

        // R2 / R3 / R4
        pulse(0);
        chk("R2 ready event", 128'(event_n), 128'(1'b0));
        stat_rd(d);
        chk("R4 ready bit", 128'(d), 128'(8'h40));
        chk("R3 event cleared", 128'(event_n), 128'(1'b1));
        stat_rd(d);
        chk("R3 status cleared", 128'(d), 128'(8'h00));
        pa = 1'b1;
        pulse(1);
        chk("R2 sent event", 128'(event_n), 128'(1'b0));
        stat_rd(d);
        chk("R4 sent+pa", 128'(d), 128'(8'h21));
        pulse(2);
        chk("R2 meas event", 128'(event_n), 128'(1'b0));
        stat_rd(d);
        pulse(3);
        chk("R2 cfg event", 128'(event_n), 128'(1'b0));
        stat_rd(d);
        chk("R3 cleared after cfg", 128'(event_n), 128'(1'b1));

        // R5
        fbeg(); sbyte(8'h55); sbyte(8'h02); sbyte(8'hFF); fend();
        chk("R5 event", 128'(event_n), 128'(1'b0));
        chk("R5 dir untouched", 128'(port_dir), 128'(6'h00));
        stat_rd(d);
        chk("R5 err code", 128'(d), 128'(8'h03));

        // R7
        fbeg(); sbyte(8'h02); sbyte(8'hFF); fend();
        chk("R7 dir bit0 low", 128'(port_dir), 128'(6'h3E));
        fbeg(); sbyte(8'h03); sbyte(8'h00); fend();
        chk("R7 out bit0 high", 128'(port_out), 128'(6'h01));
        fbeg(); sbyte(8'h03); sbyte(8'hAA); fend();
        chk("R7 out pattern", 128'(port_out), 128'(6'h2B));
        chk("R13 idle tx", 128'(tx_byte), 128'(8'h00));

        // R8
        pins = 6'h2A;
        fbeg(); sbyte(8'h04); sbyte(8'h00);
        chk("R8 pin read", 128'(tx_byte), 128'(8'h2B));
        sbyte(8'h00); fend();

        // R9
        fbeg(); sbyte(8'h0F);
        for (int j = 0; j < 16; j++) begin
            logic [7:0] e;
            e = (j < 8) ? PAC_V[8*j +: 8] : 8'h00;
            sbyte(8'h00);
            chk($sformatf("R9 code byte %0d", j), 128'(tx_byte), 128'(e));
        end
        sbyte(8'h00);
        chk("R13 after code", 128'(tx_byte), 128'(8'h00));
        fend();

        // R10
        fbeg(); sbyte(8'h12);
        for (int j = 0; j < 4; j++) begin
            logic [7:0] e;
            case (j) 0: e = 8'hA1; 1: e = 8'hB2; 2: e = 8'hC3; default: e = 8'hD4; endcase
            sbyte(8'h00);
            chk($sformatf("R10 id byte %0d", j), 128'(tx_byte), 128'(e));
        end
        fend();

        // R11
        wr_freq(32'd868000000);
        chk("R11 low edge", 128'(freq_word), 128'(32'd868000000));
        wr_freq(32'd867999999);
        chk("R11 below kept", 128'(freq_word), 128'(32'd868000000));
        stat_rd(d);
        chk("R11 err code", 128'(d), 128'(8'h07));
        wr_freq(32'd868600000);
        chk("R11 high edge", 128'(freq_word), 128'(32'd868600000));
        wr_freq(32'd868600001);
        chk("R11 above kept", 128'(freq_word), 128'(32'd868600000));
        wr_freq(32'd868300000);
        chk("R11 mid", 128'(freq_word), 128'(32'd868300000));
        stat_rd(d);

        // R6
        fbeg(); sbyte(8'h07); sbyte(8'h11); sbyte(8'h22); sbyte(8'h33); fend();
        chk("R6 len 3", 128'(pl_len), 128'(4'd3));
        chk("R6 data 3", 128'(payload), 128'(96'h332211));
        fbeg(); sbyte(8'h07);
        for (int i = 0; i < 13; i++) sbyte(8'h40 + 8'(i));
        fend();
        begin
            logic [95:0] e;
            for (int i = 0; i < 12; i++) e[8*i +: 8] = 8'h40 + 8'(i);
            chk("R6 full len", 128'(pl_len), 128'(4'd12));
            chk("R6 13th ignored", 128'(payload), 128'(e));
        end
        fbeg(); sbyte(8'h07); fend();
        chk("R6 empty len", 128'(pl_len), 128'(4'd0));
        chk("R6 empty data", 128'(payload), 128'(96'h0));
        fbeg(); sbyte(8'h07); sbyte(8'hA5); sbyte(8'h5A); fend();
        chk("R6 rewrite", 128'(payload), 128'(96'h5AA5));

        // R12
        c0 = cnt_snd;
        fbeg(); sbyte(8'h0D); fend();
        chk("R12 send pulse", 128'(cnt_snd), 128'(c0 + 1));
        c0 = cnt_mea;
        fbeg(); sbyte(8'h14); fend();
        chk("R12 meas pulse", 128'(cnt_mea), 128'(c0 + 1));

        tick();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R13 actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule